// File: doc/BRIEF.md
# Set-Associative Tag Directory with Selectable Replacement

This block is the tag directory and victim selector of a small set-associative cache. It holds a tag and a valid flag for each block frame. By default it has 4 sets of 2 ways. Each request carries a block address and a read/write flag. The block derives the set from the low address bits and compares all ways of that set against the request tag in the same cycle. It then answers with a hit/miss result and the matching way.

When a miss leads to a fill, the block names the way to be filled and says whether that way held a live line. A request field picks the policy that chooses an occupied way: pseudo-random, least recently used, or oldest fill. A second request field chooses whether a write miss installs the block or leaves the directory untouched. The block does not hold the cache data and does not talk to the lower memory level. It only reports the fill decision and the victim.

Top module: `setassoc_tagdir`

## Requirements
- R1: The set index is the block address modulo SETS, which is the low log2(SETS) address bits. The tag is the remaining upper bits. Blocks 12 and 16 share set 0, and block 13 lies in set 1.
- R2: A response reports `rsp_hit`=1 only when a way of the selected set is valid and its stored tag equals the request tag. In that case `rsp_way` gives that way. At most one way of a set can match.
- R3: On an allocating miss, if the set has an invalid way, the lowest-numbered invalid way is filled and `rsp_victim_valid`=0. Otherwise `rsp_victim_valid`=1.
- R4: With `req_policy`=2'b01 (or 2'b11), a full set evicts the way that has gone longest without a hit or a fill.
- R5: With `req_policy`=2'b10, a full set evicts the way filled earliest. Hits do not change this order.
- R6: With `req_policy`=2'b00, a full set evicts the way given by the low bits of a free-running LFSR that never holds zero. Over a long run of misses, every way is picked.
- R7: A write miss with `req_wr_alloc`=1 installs the block (`rsp_alloc`=1). With `req_wr_alloc`=0 it gives `rsp_alloc`=0 and `rsp_victim_valid`=0 and changes no directory state. Starting from an empty directory, the sequence write 100, write 100, read 200, write 200, write 100 gives 1 hit without allocation and 3 hits with allocation.
- R8: A read miss always installs the block (`rsp_alloc`=1). A hit never allocates.
- R9: While out of reset, `req_ready` is 1. Each accepted request produces exactly one response with `rsp_valid`=1 on the following cycle. No response appears without a request.
- R10: A synchronous active-low reset clears every valid flag and all replacement state. After reset, `rsp_valid`=0 and every access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Block address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_policy | input | 2 | 00 random, 01/11 LRU, 10 FIFO |
| req_wr_alloc | input | 1 | 1 = write misses allocate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag matched in a valid way |
| rsp_way | output | WAY_W | Way that hit |
| rsp_alloc | output | 1 | The miss installs the block |
| rsp_victim_way | output | WAY_W | Way being filled |
| rsp_victim_valid | output | 1 | The filled way held a valid line |

## Verification
The assertions assume that each request is sampled only while `req_ready` is high. They also assume that `req_policy` and `req_wr_alloc` stay stable within the cycle a request is accepted. The bench drives every request field at the falling edge and holds it until after the next rising edge, so each request is seen whole by exactly one edge. The assertions also rely on blocks being installed only on a miss, so that one set never holds the same tag twice. The stimulus keeps within this because the only route for installing a block is the block's own miss path.

// File: rtl/tagdir_pkg.sv
// Shared types for the tag directory.
// Assumes: the two-bit policy field of a request maps onto repl_pol_e.
package tagdir_pkg;
    typedef enum logic [1:0] {
        POL_RANDOM  = 2'b00,
        POL_LRU     = 2'b01,
        POL_FIFO    = 2'b10,
        POL_LRU_ALT = 2'b11
    } repl_pol_e;
endpackage

// File: rtl/tagdir_lfsr.sv
// Free-running Galois LFSR that supplies pseudo-random victim choices.
// Assumes: TAPS describes a maximal-length polynomial and SEED is nonzero.
module tagdir_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Advance one step every cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else
            state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/tagdir_ways.sv
// Tag and valid storage: one column per way, looked up in parallel.
// Assumes: only one write per cycle, and a tag is written only on a miss in that set.
module tagdir_ways #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 14,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  valid_vec,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vld;

        // Valid flags: cleared by reset, set when this way is filled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld <= '0;
            else if (wr_en && wr_way == WAY_W'(g))
                vld[wr_set] <= 1'b1;
        end

        // Tag storage: written on a fill into this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(g))
                tags[wr_set] <= wr_tag;
        end

        assign valid_vec[g] = vld[rd_set];
        assign hit_vec[g]   = vld[rd_set] && (tags[rd_set] == rd_tag);
    end

    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/tagdir_lru.sv
// Per-set recency ages: 0 is the most recent way, WAYS-1 the least recent.
// Assumes: an update names a single set and way; the ages of a set form a permutation.
module tagdir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] age [SETS][WAYS];
    logic [WAYS-1:0]  zero_vec;

    // Age update: the referenced way becomes 0, younger ways grow by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    age[upd_set][w] <= '0;
                else if (age[upd_set][w] < age[upd_set][upd_way])
                    age[upd_set][w] <= age[upd_set][w] + WAY_W'(1);
            end
        end
    end

    // Victim pick: the way holding the oldest age.
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++)
            if (age[rd_set][w] == WAY_W'(WAYS - 1))
                victim = WAY_W'(w);
    end

    // Marker of the most recent way, for the ordering check.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            zero_vec[w] = (age[rd_set][w] == '0);
    end

    assert_lru_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(zero_vec));
endmodule

// File: rtl/tagdir_fifo.sv
// Per-set fill pointer: it names the way whose fill is oldest.
// Assumes: while a set has invalid ways, they are filled lowest-first.
module tagdir_fifo #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] ptr [SETS];

    // Pointer move: after a fill, the next way in circular order is the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                ptr[s] <= '0;
        end else if (fill_en) begin
            ptr[fill_set] <= (fill_way == WAY_W'(WAYS - 1)) ? '0 : fill_way + WAY_W'(1);
        end
    end

    assign victim = ptr[rd_set];
endmodule

// File: rtl/setassoc_tagdir.sv
// Top of the tag directory: lookup, fill decision, victim choice, response register.
// Assumes: SETS and WAYS are powers of two, SETS >= 2, LFSR_W >= log2(WAYS).
// The response is registered; directory state is updated at the edge that accepts the request.
module setassoc_tagdir
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int LFSR_W = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_policy,
    input  logic              req_wr_alloc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_alloc,
    output logic [WAY_W-1:0]  rsp_victim_way,
    output logic              rsp_victim_valid
);
    logic             accept;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    logic [WAYS-1:0]  hit_vec, valid_vec;
    logic             hit, any_inv, do_alloc, ref_en;
    logic [WAY_W-1:0] hit_way, inv_way, pol_victim, victim_way, ref_way;
    logic [WAY_W-1:0] lru_victim, fifo_victim;
    logic [LFSR_W-1:0] lfsr_q;
    repl_pol_e        pol;

    assign req_ready = rst_n;
    assign accept    = req_valid && req_ready;
    assign set_idx   = req_addr[SET_W-1:0];
    assign tag       = req_addr[ADDR_W-1:SET_W];
    assign pol       = repl_pol_e'(req_policy);

    tagdir_ways #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_ways (
        .clk(clk), .rst_n(rst_n),
        .rd_set(set_idx), .rd_tag(tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec),
        .wr_en(do_alloc), .wr_set(set_idx), .wr_way(victim_way), .wr_tag(tag)
    );

    tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .upd_en(ref_en), .upd_set(set_idx), .upd_way(ref_way),
        .rd_set(set_idx), .victim(lru_victim)
    );

    tagdir_fifo #(.SETS(SETS), .WAYS(WAYS)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .fill_en(do_alloc), .fill_set(set_idx), .fill_way(victim_way),
        .rd_set(set_idx), .victim(fifo_victim)
    );

    tagdir_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state(lfsr_q)
    );

    // Hit encoding: turn the one-hot match vector into a way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    assign hit = |hit_vec;

    // Free-way search: the lowest-numbered invalid way of the set.
    always_comb begin
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_vec[w]) inv_way = WAY_W'(w);
    end
    assign any_inv = !(&valid_vec);

    // Policy mux: pick the victim of a full set.
    always_comb begin
        case (pol)
            POL_RANDOM: pol_victim = lfsr_q[WAY_W-1:0];
            POL_FIFO:   pol_victim = fifo_victim;
            default:    pol_victim = lru_victim;
        endcase
    end

    assign victim_way = any_inv ? inv_way : pol_victim;
    assign do_alloc   = accept && !hit && (!req_write || req_wr_alloc);
    assign ref_en     = accept && (hit || do_alloc);
    assign ref_way    = hit ? hit_way : victim_way;

    // Response register: one result per accepted request, on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_way          <= '0;
            rsp_alloc        <= 1'b0;
            rsp_victim_way   <= '0;
            rsp_victim_valid <= 1'b0;
        end else begin
            rsp_valid        <= accept;
            rsp_hit          <= accept && hit;
            rsp_way          <= hit_way;
            rsp_alloc        <= do_alloc;
            rsp_victim_way   <= victim_way;
            rsp_victim_valid <= do_alloc && !any_inv;
        end
    end

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    assert_hit_no_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_alloc);
    assert_read_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rsp_hit || rsp_alloc));
    assert_no_write_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !req_wr_alloc) |=> !rsp_alloc);
    assert_victim_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_victim_valid |-> rsp_alloc);
endmodule

// File: tb/sim_setassoc_tagdir.sv
`timescale 1ns/1ps
module sim_setassoc_tagdir;
    localparam int ADDR_W = 16;
    localparam int SETS   = 4;
    localparam int WAYS   = 2;
    localparam int WAY_W  = 1;

    typedef struct {
        int   addr;
        logic wr;
        int   pol;
        logic wa;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wr_alloc = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_policy = 2'b01;
    logic req_ready, rsp_valid, rsp_hit, rsp_alloc, rsp_victim_valid;
    logic [WAY_W-1:0] rsp_way, rsp_victim_way;

    int checks = 0, errors = 0, hits = 0, t = 0;
    int last_hit, last_vway, last_vv;
    int seen [WAYS];
    req_t q[$];
    bit m_valid [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_use [SETS][WAYS];
    int m_fill [SETS][WAYS];
    bit done = 0;

    always #2.5 clk = ~clk;

    setassoc_tagdir #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_policy(req_policy),
        .req_wr_alloc(req_wr_alloc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_alloc(rsp_alloc), .rsp_victim_way(rsp_victim_way),
        .rsp_victim_valid(rsp_victim_valid)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_use[s][w] = 0; m_fill[s][w] = 0;
            end
        for (int w = 0; w < WAYS; w++) seen[w] = 0;
        hits = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R9", "req_ready out of reset", req_ready, 1);
    endtask

    // Driver: present one request for one edge and queue it for the monitor.
    task automatic access(input int a, input logic w, input int p, input logic wa);
        req_t it;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_write = w;
        req_policy = 2'(p); req_wr_alloc = wa;
        it.addr = a; it.wr = w; it.pol = p; it.wa = wa;
        q.push_back(it);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R9", "responses outstanding", q.size(), 0);
    endtask

    // Monitor: pop the oldest request, predict its result, compare, update the model.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R9", "response without request", 1, 0);
            end else begin
                req_t it;
                int s, tg, hw, ev, best;
                bit h, al, inv;
                it = q.pop_front();
                s = it.addr % SETS; tg = it.addr / SETS;
                h = 0; hw = 0;
                for (int w = 0; w < WAYS; w++)
                    if (m_valid[s][w] && m_tag[s][w] == tg) begin h = 1; hw = w; end
                al = !h && (!it.wr || it.wa);
                chk(rsp_hit == h, "R2", "hit", rsp_hit, h);
                if (h) chk(rsp_way == WAY_W'(hw), "R2", "hit way", rsp_way, hw);
                if (it.wr) chk(rsp_alloc == al, "R7", "write alloc", rsp_alloc, al);
                else       chk(rsp_alloc == al, "R8", "read alloc", rsp_alloc, al);
                inv = 0; ev = 0;
                for (int w = WAYS - 1; w >= 0; w--)
                    if (!m_valid[s][w]) begin inv = 1; ev = w; end
                if (al) begin
                    chk(rsp_victim_valid == !inv, "R3", "victim live flag", rsp_victim_valid, !inv);
                    if (inv) begin
                        chk(rsp_victim_way == WAY_W'(ev), "R3", "free way", rsp_victim_way, ev);
                    end else if (it.pol == 0) begin
                        ev = int'(rsp_victim_way);
                        chk(ev < WAYS, "R6", "random way range", ev, WAYS - 1);
                        seen[ev]++;
                    end else if (it.pol == 2) begin
                        best = 0;
                        for (int w = 1; w < WAYS; w++) if (m_fill[s][w] < m_fill[s][best]) best = w;
                        ev = best;
                        chk(rsp_victim_way == WAY_W'(ev), "R5", "fifo victim", rsp_victim_way, ev);
                    end else begin
                        best = 0;
                        for (int w = 1; w < WAYS; w++) if (m_use[s][w] < m_use[s][best]) best = w;
                        ev = best;
                        chk(rsp_victim_way == WAY_W'(ev), "R4", "lru victim", rsp_victim_way, ev);
                    end
                end else begin
                    chk(rsp_victim_valid == 1'b0, "R7", "no victim without fill", rsp_victim_valid, 0);
                end
                t++;
                if (h) begin m_use[s][hw] = t; hits++; end
                if (al) begin
                    m_valid[s][ev] = 1; m_tag[s][ev] = tg; m_use[s][ev] = t; m_fill[s][ev] = t;
                end
                last_hit = h ? 1 : 0; last_hit = rsp_hit; last_vway = rsp_victim_way; last_vv = rsp_victim_valid;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R9", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();

        // R7: no-write-allocate sequence gives exactly one hit
        access(100, 1, 1, 0); access(100, 1, 1, 0); access(200, 0, 1, 0);
        access(200, 1, 1, 0); access(100, 1, 1, 0);
        drain();
        chk(hits == 1, "R7", "hits without allocation", hits, 1);

        // R7: write-allocate sequence gives three hits
        do_reset();
        access(100, 1, 1, 1); access(100, 1, 1, 1); access(200, 0, 1, 1);
        access(200, 1, 1, 1); access(100, 1, 1, 1);
        drain();
        chk(hits == 3, "R7", "hits with allocation", hits, 3);

        // R10: reset forgets installed blocks
        do_reset();
        access(100, 0, 1, 1);
        drain();
        chk(last_hit == 0, "R10", "hit after reset", last_hit, 0);

        // R1: blocks 12 and 16 share set 0; block 13 lands in free set 1
        do_reset();
        access(12, 0, 1, 1); access(16, 0, 1, 1); access(13, 0, 1, 1);
        drain();
        chk(last_vv == 0, "R1", "set 1 still free", last_vv, 0);
        access(20, 0, 1, 1);
        drain();
        chk(last_vv == 1, "R1", "set 0 full on third block", last_vv, 1);

        // R4: LRU keeps the recently hit way
        do_reset();
        access(2, 0, 1, 1); access(6, 0, 1, 1); access(2, 0, 1, 1); access(10, 0, 1, 1);
        drain();
        chk(last_vway == 1, "R4", "lru evicts way 1", last_vway, 1);

        // R5: FIFO ignores the hit and evicts the first fill
        do_reset();
        access(2, 0, 2, 1); access(6, 0, 2, 1); access(2, 0, 2, 1); access(10, 0, 2, 1);
        drain();
        chk(last_vway == 0, "R5", "fifo evicts way 0", last_vway, 0);

        // R4: write hit with no-write-allocate still refreshes recency
        do_reset();
        access(1, 0, 1, 0); access(5, 0, 1, 0); access(1, 1, 1, 0); access(9, 0, 3, 0);
        drain();
        chk(last_vway == 1, "R4", "write hit refreshes lru", last_vway, 1);

        // R6: random policy over a long run of misses in set 3
        do_reset();
        access(3, 0, 0, 1); access(7, 0, 0, 1);
        for (int k = 0; k < 24; k++) access(11 + 4 * k, 0, 0, 1);
        drain();
        for (int w = 0; w < WAYS; w++)
            chk(seen[w] > 0, "R6", "way picked by random", seen[w], 1);

        // Mixed traffic across sets and policies, checked by the scoreboard
        do_reset();
        for (int k = 0; k < 60; k++)
            access((k * 7) % 23, (k % 3) == 1, k % 4, (k % 5) != 0);
        drain();

        finish_run();
    end
endmodule